// File: doc/BRIEF.md
# Message Object Transfer Engine

This block sits between a host register bus and a RAM of message objects. Each object holds an acceptance mask, an arbitration word, a 16-bit control word and eight data bytes. The host loads a set of staging registers and then writes a single command word. That word names the object and says which way the transfer runs. It also picks the register groups that take part and may ask for flag side effects on the stored object. The engine then runs a short fixed sequence on the RAM port: it fetches the object and writes it back, merged.

During the sequence the engine shows a busy flag in the command register. Staging and command writes that arrive while busy is set are dropped. A read transfer copies the selected groups of the object into staging. It can also clear the object's interrupt-pending and new-data flags, and each of these clears is chosen on its own. A write transfer copies the selected staging groups into the object. It can also raise the object's transmit request. The same write path invalidates an object: the host writes the arbitration and control groups with the valid bit clear.

Top module: `msgobj_xfer_engine`

## Requirements
- R1: After reset the busy flag is 0, neither RAM strobe is active, and every staging register reads back as zero.
- R2: A host write to register 0 starts a transfer when busy is clear and the value is valid. The object number sits in bits 15:0 and the command bits sit in bits 23:16. Busy is visible at bit 15 of register 0 from the next cycle and clears within two cycles. A poll of register 0 returns the command bits at 23:16 and the object number in the low bits.
- R3: A command naming object 0, or any object above 32, starts no transfer. Busy stays 0 and the RAM is not written.
- R4: A write transfer has command bit 7 set. It copies the selected staging groups into the object: bit 6 mask, bit 5 arbitration, bit 4 control, bit 1 data bytes 0 to 3, bit 0 data bytes 4 to 7. Unselected object fields and all staging registers stay unchanged. Writing arbitration bit 31 as 0 together with the control group invalidates the object.
- R5: A read transfer has command bit 7 clear. It copies the selected object groups, with their values before any flag change, into staging. Unselected staging registers stay unchanged. The stored mask, arbitration and data fields are not altered.
- R6: On a read, command bit 3 clears control bit 13 (interrupt pending) of the stored object. Command bit 2 clears control bit 15 (new data). With bit 3 set and bit 2 clear, new data is kept. With both bits clear, the stored control word is unchanged.
- R7: On a write, command bit 2 sets control bit 8 (transmit request) of the stored object. Command bit 3 clears control bit 13. Both changes act after the group copy.
- R8: While busy is set, writes to the staging registers and to the command register have no effect.
- R9: Staging registers read back at the addresses where they are written: 1 mask, 2 arbitration, 3 control (bits 15:0, upper bits read 0), 4 data bytes 0 to 3, 5 data bytes 4 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | ADDR_W | Host register address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr, combinational |
| busy | output | 1 | Transfer in progress |
| ram_re | output | 1 | Object RAM read strobe, data returned one cycle later |
| ram_we | output | 1 | Object RAM write strobe |
| ram_addr | output | RAM_AW | Object index, object number minus one |
| ram_wdata | output | 144 | Object to store: {mask, arb, ctrl, data bytes 0-3, data bytes 4-7} |
| ram_rdata | input | 144 | Object read, same packing as ram_wdata |

## Verification
The main transfer is tried with command words that mix both directions, single and multiple groups, and each flag bit alone and in pairs. This shows whether group selection and side effects are decoded independently. A read with only the interrupt clear tells a correct new-data hold apart from a merged clear. A read with no groups selected shows that flag clears also act when the control group is not copied. Write vectors on the first and last object, plus an invalidating write, check address translation and field isolation. Directed cases send commands to objects 0 and 33, and send staging and command writes that land on a busy cycle.

// File: rtl/msgobj_pkg.sv
package msgobj_pkg;

   typedef struct packed {
      logic [31:0] mask;
      logic [31:0] arb;
      logic [15:0] ctrl;
      logic [31:0] data_a;
      logic [31:0] data_b;
   } mobj_t;

   localparam int MOBJ_W = $bits(mobj_t);

   // command bit positions (bits 23:16 of the command word)
   localparam int CM_WRITE = 7;
   localparam int CM_MASK  = 6;
   localparam int CM_ARB   = 5;
   localparam int CM_CTRL  = 4;
   localparam int CM_CLRIP = 3;
   localparam int CM_TXNEW = 2;
   localparam int CM_DA    = 1;
   localparam int CM_DB    = 0;

   // control word flag positions
   localparam int CT_NEWDAT = 15;
   localparam int CT_INTPND = 13;
   localparam int CT_TXRQST = 8;

   // host register addresses
   localparam int RA_CMD    = 0;
   localparam int RA_MASK   = 1;
   localparam int RA_ARB    = 2;
   localparam int RA_CTRL   = 3;
   localparam int RA_DATA_A = 4;
   localparam int RA_DATA_B = 5;

endpackage

// File: rtl/msgobj_cmd_decode.sv
module msgobj_cmd_decode #(
   parameter int NUM_OBJ = 32,
   parameter int OBJN_W  = 6
) (
   input  logic [23:0]       cmd_word,
   output logic [7:0]        cmd_mask,
   output logic [OBJN_W-1:0] obj_num,
   output logic              obj_ok
);
   logic [15:0] req;

   assign req      = cmd_word[15:0];
   assign cmd_mask = cmd_word[23:16];
   assign obj_num  = req[OBJN_W-1:0];
   assign obj_ok   = (req != 16'd0) && (32'(req) <= NUM_OBJ);

endmodule

// File: rtl/msgobj_merge.sv
module msgobj_merge
   import msgobj_pkg::*;
(
   input  logic [7:0] cmd,
   input  mobj_t      stage,
   input  mobj_t      stored,
   output mobj_t      obj_out,
   output mobj_t      stage_out
);
   always_comb begin
      obj_out   = stored;
      stage_out = stage;
      if (cmd[CM_WRITE]) begin
         if (cmd[CM_MASK]) obj_out.mask   = stage.mask;
         if (cmd[CM_ARB])  obj_out.arb    = stage.arb;
         if (cmd[CM_CTRL]) obj_out.ctrl   = stage.ctrl;
         if (cmd[CM_DA])   obj_out.data_a = stage.data_a;
         if (cmd[CM_DB])   obj_out.data_b = stage.data_b;
         if (cmd[CM_TXNEW]) obj_out.ctrl[CT_TXRQST] = 1'b1;
         if (cmd[CM_CLRIP]) obj_out.ctrl[CT_INTPND] = 1'b0;
      end else begin
         if (cmd[CM_MASK]) stage_out.mask   = stored.mask;
         if (cmd[CM_ARB])  stage_out.arb    = stored.arb;
         if (cmd[CM_CTRL]) stage_out.ctrl   = stored.ctrl;
         if (cmd[CM_DA])   stage_out.data_a = stored.data_a;
         if (cmd[CM_DB])   stage_out.data_b = stored.data_b;
         if (cmd[CM_CLRIP]) obj_out.ctrl[CT_INTPND] = 1'b0;
         if (cmd[CM_TXNEW]) obj_out.ctrl[CT_NEWDAT] = 1'b0;
      end
   end

endmodule

// File: rtl/msgobj_staging.sv
module msgobj_staging
   import msgobj_pkg::*;
#(
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [31:0]       host_wdata,
   input  logic              hold,
   input  logic              load_en,
   input  mobj_t             load_val,
   output mobj_t             stage
);
   localparam int NREG = 5;

   function automatic logic [31:0] pick(input int idx, input mobj_t v);
      case (idx)
         0:       return v.mask;
         1:       return v.arb;
         2:       return {16'h0000, v.ctrl};
         3:       return v.data_a;
         default: return v.data_b;
      endcase
   endfunction

   generate
      for (genvar g = 0; g < NREG; g++) begin : g_reg
         localparam int W = (g == 2) ? 16 : 32;
         logic [W-1:0] r;
         logic         hit;
         assign hit = host_we && !hold && (host_addr == ADDR_W'(g + 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       r <= '0;
            else if (load_en) r <= W'(pick(g, load_val));
            else if (hit)     r <= host_wdata[W-1:0];
         end
      end
   endgenerate

   always_comb begin
      stage.mask   = g_reg[0].r;
      stage.arb    = g_reg[1].r;
      stage.ctrl   = g_reg[2].r;
      stage.data_a = g_reg[3].r;
      stage.data_b = g_reg[4].r;
   end

endmodule

// File: rtl/msgobj_xfer_engine.sv
module msgobj_xfer_engine
   import msgobj_pkg::*;
#(
   parameter int NUM_OBJ = 32,
   parameter int ADDR_W  = 3,
   localparam int RAM_AW = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1,
   localparam int OBJN_W = $clog2(NUM_OBJ + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [31:0]       host_wdata,
   output logic [31:0]       host_rdata,
   output logic              busy,
   output logic              ram_re,
   output logic              ram_we,
   output logic [RAM_AW-1:0] ram_addr,
   output logic [MOBJ_W-1:0] ram_wdata,
   input  logic [MOBJ_W-1:0] ram_rdata
);
   generate
      if (NUM_OBJ < 1 || OBJN_W > 15) begin : g_bad_num_obj
         $error("msgobj_xfer_engine: NUM_OBJ out of range");
      end
      if (ADDR_W < 3) begin : g_bad_addr_w
         $error("msgobj_xfer_engine: ADDR_W must be at least 3");
      end
   endgenerate

   typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_APPLY} xfer_state_t;

   xfer_state_t       state;
   logic [7:0]        cmd_q;
   logic [OBJN_W-1:0] obj_q;
   logic [7:0]        dec_mask;
   logic [OBJN_W-1:0] dec_obj;
   logic              dec_ok;
   logic              cmd_hit;
   logic              start;
   mobj_t             stored, stage, obj_new, stage_new;

   msgobj_cmd_decode #(.NUM_OBJ(NUM_OBJ), .OBJN_W(OBJN_W)) u_dec (
      .cmd_word (host_wdata[23:0]),
      .cmd_mask (dec_mask),
      .obj_num  (dec_obj),
      .obj_ok   (dec_ok)
   );

   assign cmd_hit = host_we && (host_addr == ADDR_W'(RA_CMD));
   assign start   = cmd_hit && (state == ST_IDLE) && dec_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cmd_q <= '0;
         obj_q <= '0;
      end else begin
         case (state)
            ST_IDLE: if (start) begin
               state <= ST_FETCH;
               cmd_q <= dec_mask;
               obj_q <= dec_obj;
            end
            ST_FETCH: state <= ST_APPLY;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (state != ST_IDLE);
   assign ram_re    = (state == ST_FETCH);
   assign ram_we    = (state == ST_APPLY);
   assign ram_addr  = RAM_AW'(obj_q - OBJN_W'(1));
   assign stored    = mobj_t'(ram_rdata);
   assign ram_wdata = obj_new;

   msgobj_merge u_merge (
      .cmd       (cmd_q),
      .stage     (stage),
      .stored    (stored),
      .obj_out   (obj_new),
      .stage_out (stage_new)
   );

   msgobj_staging #(.ADDR_W(ADDR_W)) u_stage (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_we    (host_we),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .hold       (busy),
      .load_en    (ram_we && !cmd_q[CM_WRITE]),
      .load_val   (stage_new),
      .stage      (stage)
   );

   always_comb begin
      case (host_addr)
         ADDR_W'(RA_CMD):
            host_rdata = {8'h00, cmd_q, busy, {(15-OBJN_W){1'b0}}, obj_q};
         ADDR_W'(RA_MASK):   host_rdata = stage.mask;
         ADDR_W'(RA_ARB):    host_rdata = stage.arb;
         ADDR_W'(RA_CTRL):   host_rdata = {16'h0000, stage.ctrl};
         ADDR_W'(RA_DATA_A): host_rdata = stage.data_a;
         ADDR_W'(RA_DATA_B): host_rdata = stage.data_b;
         default:            host_rdata = 32'h0000_0000;
      endcase
   end

endmodule

// File: rtl/msgobj_xfer_chk.sv
module msgobj_xfer_chk
   import msgobj_pkg::*;
#(
   parameter int NUM_OBJ = 32,
   parameter int ADDR_W  = 3,
   parameter int RAM_AW  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_we,
   input logic [ADDR_W-1:0] host_addr,
   input logic [15:0]       req_lo,
   input logic              busy,
   input logic              ram_re,
   input logic              ram_we,
   input logic [RAM_AW-1:0] ram_addr,
   input logic [MOBJ_W-1:0] ram_rdata,
   input logic [MOBJ_W-1:0] ram_wdata,
   input logic [7:0]        cmd_q,
   input mobj_t             stage_vec
);
   mobj_t rd, wr;
   assign rd = mobj_t'(ram_rdata);
   assign wr = mobj_t'(ram_wdata);

   AST_BUSY_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |=> !busy);  // R2

   AST_WE_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> ($past(ram_re) && $stable(ram_addr)));  // R2

   AST_BAD_OBJ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (host_we && host_addr == '0 && !busy &&
       (req_lo == 16'd0 || 32'(req_lo) > NUM_OBJ)) |=> !busy);  // R3

   AST_READ_KEEPS_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we && !cmd_q[CM_WRITE]) |->
      (wr.mask == rd.mask && wr.arb == rd.arb &&
       wr.data_a == rd.data_a && wr.data_b == rd.data_b));  // R5

   AST_NEWDAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we && !cmd_q[CM_WRITE] && !cmd_q[CM_TXNEW]) |->
      (wr.ctrl[CT_NEWDAT] == rd.ctrl[CT_NEWDAT]));  // R6

   AST_READ_CTRL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we && !cmd_q[CM_WRITE] && !cmd_q[CM_TXNEW] && !cmd_q[CM_CLRIP]) |->
      (wr.ctrl == rd.ctrl));  // R6

   AST_TXRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we && cmd_q[CM_WRITE] && cmd_q[CM_TXNEW]) |->
      wr.ctrl[CT_TXRQST]);  // R7

   AST_STAGE_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !ram_we) |=> $stable(stage_vec));  // R8

   AST_CMD_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(cmd_q));  // R8

endmodule

bind msgobj_xfer_engine msgobj_xfer_chk #(
   .NUM_OBJ (NUM_OBJ),
   .ADDR_W  (ADDR_W),
   .RAM_AW  (RAM_AW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .host_we   (host_we),
   .host_addr (host_addr),
   .req_lo    (host_wdata[15:0]),
   .busy      (busy),
   .ram_re    (ram_re),
   .ram_we    (ram_we),
   .ram_addr  (ram_addr),
   .ram_rdata (ram_rdata),
   .ram_wdata (ram_wdata),
   .cmd_q     (cmd_q),
   .stage_vec (stage)
);

// File: tb/tb_msgobj_xfer_engine.sv
module tb_msgobj_xfer_engine;
   import msgobj_pkg::*;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          host_we = 1'b0;
   logic [2:0]    host_addr = '0;
   logic [31:0]   host_wdata = '0;
   logic [31:0]   host_rdata;
   logic          busy, ram_re, ram_we;
   logic [4:0]    ram_addr;
   logic [143:0]  ram_wdata;
   logic [143:0]  ram_rdata = '0;

   int n_chk = 0;
   int n_err = 0;
   int we_count = 0;

   mobj_t mem [32];

   always #10 clk = ~clk;

   msgobj_xfer_engine dut (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy),
      .ram_re(ram_re), .ram_we(ram_we), .ram_addr(ram_addr),
      .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
   );

   // bench-side object RAM, one cycle read latency
   always @(posedge clk) begin
      if (ram_we) begin
         mem[ram_addr] <= mobj_t'(ram_wdata);
         we_count <= we_count + 1;
      end
      if (ram_re) ram_rdata <= mem[ram_addr];
   end

   // {command bits, object number}
   localparam logic [13:0] VEC_TAB [8] = '{
      {8'hF3, 6'd1},   // write every group, object 1
      {8'hA4, 6'd32},  // write arb, set tx request, last object
      {8'h7F, 6'd5},   // read every group, clear both flags
      {8'h28, 6'd7},   // read arb, clear int pending only
      {8'h03, 6'd12},  // read data only
      {8'hB0, 6'd9},   // invalidate: write arb+ctrl with valid clear
      {8'h8A, 6'd20},  // write data A, clear int pending
      {8'h04, 6'd3}    // read nothing, clear new data
   };

   function automatic mobj_t obj_pat(input int i);
      mobj_t v;
      v.mask   = 32'hF0F0_0000 + 32'(i);
      v.arb    = 32'hA000_0000 | 32'(i);
      v.ctrl   = 16'hA000 | 16'(i & 15);
      v.data_a = 32'h0102_0300 + 32'(i);
      v.data_b = 32'hC0DE_0000 + 32'(i);
      return v;
   endfunction

   function automatic mobj_t stg_pat(input int k);
      mobj_t v;
      v.mask   = 32'h1111_0000 + 32'(k);
      v.arb    = 32'h4000_0100 + 32'(k);
      v.ctrl   = 16'h0080 | 16'(k);
      v.data_a = 32'h5555_0000 + 32'(k);
      v.data_b = 32'h6666_0000 + 32'(k);
      return v;
   endfunction

   // expected results written from the requirements
   task automatic expect_xfer(input logic [7:0] m, input mobj_t st, input mobj_t ob,
                              output mobj_t eo, output mobj_t es);
      eo = ob;
      es = st;
      if (m[7]) begin
         if (m[6]) eo.mask = st.mask;
         if (m[5]) eo.arb = st.arb;
         if (m[4]) eo.ctrl = st.ctrl;
         if (m[1]) eo.data_a = st.data_a;
         if (m[0]) eo.data_b = st.data_b;
         if (m[2]) eo.ctrl[8] = 1'b1;
         if (m[3]) eo.ctrl[13] = 1'b0;
      end else begin
         if (m[6]) es.mask = ob.mask;
         if (m[5]) es.arb = ob.arb;
         if (m[4]) es.ctrl = ob.ctrl;
         if (m[1]) es.data_a = ob.data_a;
         if (m[0]) es.data_b = ob.data_b;
         if (m[3]) eo.ctrl[13] = 1'b0;
         if (m[2]) eo.ctrl[15] = 1'b0;
      end
   endtask

   task automatic check(input string req, input string what,
                        input logic [143:0] act, input logic [143:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic host_write(input int a, input logic [31:0] d);
      @(negedge clk);
      host_we = 1'b1;
      host_addr = 3'(a);
      host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic host_read(input int a, output logic [31:0] d);
      @(negedge clk);
      host_addr = 3'(a);
      #1;
      d = host_rdata;
   endtask

   task automatic load_stage(input mobj_t s);
      host_write(RA_MASK, s.mask);
      host_write(RA_ARB, s.arb);
      host_write(RA_CTRL, {16'h0000, s.ctrl});
      host_write(RA_DATA_A, s.data_a);
      host_write(RA_DATA_B, s.data_b);
   endtask

   task automatic read_stage(output mobj_t s);
      logic [31:0] d;
      host_read(RA_MASK, d);   s.mask = d;
      host_read(RA_ARB, d);    s.arb = d;
      host_read(RA_CTRL, d);   s.ctrl = d[15:0];
      host_read(RA_DATA_A, d); s.data_a = d;
      host_read(RA_DATA_B, d); s.data_b = d;
   endtask

   // polls register 0 until busy clears; returns the poll count
   task automatic wait_idle(output int polls);
      logic [31:0] d;
      polls = 0;
      do begin
         host_read(RA_CMD, d);
         polls++;
      end while (d[15] && polls < 20);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin : main
      mobj_t st, ob, eo, es, got;
      logic [31:0] d;
      int polls, wc;

      for (int i = 0; i < 32; i++) mem[i] = obj_pat(i + 1);
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "busy", 144'(busy), 144'(0));
      check("R1", "ram strobes", 144'({ram_re, ram_we}), 144'(0));
      rst_n = 1'b1;
      read_stage(got);
      check("R1", "staging", got, '0);

      // R9: readback of staging, ctrl upper bits read zero
      host_write(RA_CTRL, 32'hFFFF_FFFF);
      host_read(RA_CTRL, d);
      check("R9", "ctrl readback", 144'(d), 144'(32'h0000_FFFF));
      host_write(RA_DATA_B, 32'h89AB_CDEF);
      host_read(RA_DATA_B, d);
      check("R9", "data B readback", 144'(d), 144'(32'h89AB_CDEF));

      // table of vectors
      for (int k = 0; k < 8; k++) begin
         logic [7:0] m;
         int o;
         m = VEC_TAB[k][13:6];
         o = int'(VEC_TAB[k][5:0]);
         st = stg_pat(k);
         load_stage(st);
         ob = mem[o - 1];
         expect_xfer(m, st, ob, eo, es);
         host_write(RA_CMD, {8'h00, m, 16'(o)});
         check("R2", "busy after command", 144'(busy), 144'(1));
         wait_idle(polls);
         check("R2", "polls to idle", 144'(polls <= 6), 144'(1));
         check(m[7] ? "R4" : "R5", "stored object", mem[o - 1], eo);
         read_stage(got);
         check(m[7] ? "R4" : "R5", "staging", got, es);
         if (m[2] || m[3])
            check(m[7] ? "R7" : "R6", "stored ctrl flags",
                  144'(mem[o - 1].ctrl), 144'(eo.ctrl));
         if (k == 0) begin
            host_read(RA_CMD, d);
            check("R2", "command readback", 144'(d), 144'(32'h00F3_0001));
         end
      end

      // R3: object 0 and object 33 ignored
      wc = we_count;
      host_write(RA_CMD, {8'h00, 8'hF3, 16'd0});
      check("R3", "busy for object 0", 144'(busy), 144'(0));
      host_write(RA_CMD, {8'h00, 8'hF3, 16'd33});
      check("R3", "busy for object 33", 144'(busy), 144'(0));
      repeat (3) @(negedge clk);
      check("R3", "ram writes", 144'(we_count), 144'(wc));

      // R8: staging write landing on a busy cycle
      host_write(RA_MASK, 32'h1234_5678);
      host_write(RA_CMD, {8'h00, 8'h20, 16'd2});
      host_write(RA_MASK, 32'hDEAD_BEEF);
      wait_idle(polls);
      host_read(RA_MASK, d);
      check("R8", "mask after busy write", 144'(d), 144'(32'h1234_5678));
      host_read(RA_ARB, d);
      check("R5", "arb loaded", 144'(d), 144'(obj_pat(2).arb));

      // R8: second command during busy
      st = stg_pat(9);
      load_stage(st);
      ob = mem[5];
      host_write(RA_CMD, {8'h00, 8'hF3, 16'd4});
      host_write(RA_CMD, {8'h00, 8'hF3, 16'd6});
      wait_idle(polls);
      check("R8", "object 6 untouched", mem[5], ob);
      check("R4", "object 4 written", mem[3], st);

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule